// File: doc/BRIEF.md
# Parallel Bus Target Phase Sequencer

This block is the phase controller on the target side of a legacy eight-bit parallel disk bus. It watches the bus reset, select and busy lines and the data lines. It answers a selection that carries its own ID bit, but only when a logical unit is attached. It then walks the bus through the command phase, an execution wait, an optional data-in or data-out phase, one status byte, one message-in byte, and back to bus-free. It drives the busy line and the three phase lines (message, control/data, input/output).

The sequencer moves no bytes itself. Each transfer phase is handed to a separate handshake engine with a start pulse and a byte count, and the engine reports back with a done pulse. When the command bytes are in, a neighbouring decoder receives a one-cycle execution request. The decoder returns the data direction, the data length, the status byte and the message byte. A programmable minimum execution time, counted in clock cycles, holds the block in the execution wait before any data or status phase.

Top module: `tgt_phase_seq`

## Requirements
- R1: After reset, and whenever the bus is free, drv_bsy, drv_msg, drv_cd and drv_io are all 0, xfer_start is 0 and xfer_len is 0.
- R2: The target is selected only when bus_sel is 1, bus_bsy_in is 0 and bit cfg_id of bus_data_in is 1, all in the same cycle. drv_bsy goes to 1 in the next cycle. A wrong ID bit, or a bus that is already busy, leaves drv_bsy at 0.
- R3: While cfg_lun_present is 0, a selection that is otherwise valid is ignored and drv_bsy stays 0.
- R4: Once the target is selected, the cycle after bus_sel drops to 0 starts the command phase. The command phase issues a transfer of 6 bytes.
- R5: The phase lines (drv_msg, drv_cd, drv_io) read 010 for command, 001 for data-in, 000 for data-out, 011 for status and 111 for message-in.
- R6: When the command transfer completes, exec_req pulses for exactly the first cycle of the execution wait. The decoder reply, given with dec_valid, is captured. dec_dir encodes 0 = no data, 1 = data-in, 2 = data-out, and 3 = no data. A data phase transfers dec_len bytes.
- R7: With cfg_min_exec = M, the phase lines leave 010 exactly max(M,1)+1 cycles after the exec_req cycle when the decoder answers in the exec_req cycle. M = 0 disables the hold.
- R8: A decoder reply with no data direction, or with dec_len = 0, goes straight from the execution wait to the status phase.
- R9: The status phase transfers 1 byte with tx_byte = the captured status. It is followed by a 1-byte message-in phase with tx_byte = the captured message, and then by bus-free.
- R10: In bus-free the stored status and message bytes are cleared to 0x00, so tx_byte reads 0x00.
- R11: bus_rst = 1 in any cycle puts the block into bus-free by the next cycle. The lines are released, and the transfer length and execution timer are cleared.
- R12: xfer_start is a one-cycle pulse. The phase lines hold the same value in the cycle before it, and they do not change while a transfer is outstanding (from xfer_start until xfer_done).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset line, active high |
| bus_sel | input | 1 | Bus select line |
| bus_bsy_in | input | 1 | Busy line as seen on the bus |
| bus_data_in | input | 8 | Bus data lines |
| cfg_id | input | 3 | Target ID |
| cfg_lun_present | input | 1 | A logical unit is attached |
| cfg_min_exec | input | 16 | Minimum execution time in cycles |
| exec_req | output | 1 | Command received, start decoding |
| dec_valid | input | 1 | Decoder reply valid |
| dec_dir | input | 2 | Data direction from decoder |
| dec_len | input | 16 | Data length from decoder |
| dec_status | input | 8 | Status byte from decoder |
| dec_message | input | 8 | Message byte from decoder |
| xfer_start | output | 1 | Start pulse to handshake engine |
| xfer_len | output | 16 | Bytes to transfer in this phase |
| xfer_done | input | 1 | Handshake engine finished |
| tx_byte | output | 8 | Status or message byte to send |
| drv_bsy | output | 1 | Busy line driven by target |
| drv_msg | output | 1 | Message phase line |
| drv_cd | output | 1 | Control/data phase line |
| drv_io | output | 1 | Input/output phase line |

## Verification
The assertions watch, on every cycle, that a valid selection raises busy, that a missing logical unit or a bus reset keeps or drops busy low, and that each start pulse lasts one cycle and comes on settled phase lines. They also check that the lines stay frozen while a transfer is outstanding, and that command and status transfers carry lengths of 6 and 1. Other behaviours only show in the bench's scenarios: the exact number of cycles of the execution hold for several minimum times, the choice between data-in, data-out and the skip to status, the status and message bytes seen in order, and the cleared bytes after bus-free.

// File: rtl/tgt_phase_pkg.sv
package tgt_phase_pkg;

  typedef enum logic [2:0] {
    ST_FREE,
    ST_SELECT,
    ST_CMD,
    ST_EXEC,
    ST_DIN,
    ST_DOUT,
    ST_STAT,
    ST_MSGI
  } seq_state_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_IN   = 2'd1,
    DIR_OUT  = 2'd2,
    DIR_RSVD = 2'd3
  } data_dir_e;

  // sub-steps of a transfer phase: settle lines, launch, wait for done
  typedef enum logic [1:0] {
    STEP_SETTLE = 2'd0,
    STEP_LAUNCH = 2'd1,
    STEP_WAIT   = 2'd2
  } xfer_step_e;

  // phase line value {msg, cd, io} for a state
  function automatic logic [2:0] phase_code(input seq_state_e s);
    case (s)
      ST_CMD, ST_EXEC: phase_code = 3'b010;
      ST_DIN:          phase_code = 3'b001;
      ST_DOUT:         phase_code = 3'b000;
      ST_STAT:         phase_code = 3'b011;
      ST_MSGI:         phase_code = 3'b111;
      default:         phase_code = 3'b000;
    endcase
  endfunction

  function automatic logic is_xfer_state(input seq_state_e s);
    is_xfer_state = (s == ST_CMD) || (s == ST_DIN) || (s == ST_DOUT) ||
                    (s == ST_STAT) || (s == ST_MSGI);
  endfunction

endpackage

// File: rtl/tgt_rst_sync.sv
module tgt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tgt_sel_match.sv
module tgt_sel_match #(
  parameter int ID_W = 3,
  localparam int DATA_W = 1 << ID_W
) (
  input  logic              bus_sel,
  input  logic              bus_bsy_in,
  input  logic [DATA_W-1:0] bus_data_in,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              cfg_lun_present,
  output logic              sel_hit
);

  logic [DATA_W-1:0] id_onehot;

  for (genvar g = 0; g < DATA_W; g++) begin : g_dec
    assign id_onehot[g] = (cfg_id == ID_W'(g));
  end

  logic id_seen;
  assign id_seen = |(id_onehot & bus_data_in);
  assign sel_hit = bus_sel && !bus_bsy_in && id_seen && cfg_lun_present;

endmodule

// File: rtl/tgt_exec_timer.sv
module tgt_exec_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             elapsed
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr || (cnt_q != {CNT_W{1'b1}});

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    if (clr) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign elapsed = (cnt_q >= limit);

endmodule

// File: rtl/tgt_phase_seq.sv
module tgt_phase_seq
  import tgt_phase_pkg::*;
#(
  parameter int ID_W    = 3,
  parameter int CNT_W   = 16,
  parameter int LEN_W   = 16,
  parameter int CMD_LEN = 6,
  localparam int DATA_W = 1 << ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              bus_sel,
  input  logic              bus_bsy_in,
  input  logic [DATA_W-1:0] bus_data_in,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              cfg_lun_present,
  input  logic [CNT_W-1:0]  cfg_min_exec,
  output logic              exec_req,
  input  logic              dec_valid,
  input  logic [1:0]        dec_dir,
  input  logic [LEN_W-1:0]  dec_len,
  input  logic [7:0]        dec_status,
  input  logic [7:0]        dec_message,
  output logic              xfer_start,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_done,
  output logic [7:0]        tx_byte,
  output logic              drv_bsy,
  output logic              drv_msg,
  output logic              drv_cd,
  output logic              drv_io
);

  logic rst_n_int;

  tgt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // ---------------- selection and execution timer ----------------
  logic sel_hit;

  tgt_sel_match #(.ID_W(ID_W)) u_sel (
    .bus_sel         (bus_sel),
    .bus_bsy_in      (bus_bsy_in),
    .bus_data_in     (bus_data_in),
    .cfg_id          (cfg_id),
    .cfg_lun_present (cfg_lun_present),
    .sel_hit         (sel_hit)
  );

  seq_state_e state_q, state_d;
  xfer_step_e step_q, step_d;
  logic       timer_clr, timer_ok;

  tgt_exec_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .clr     (timer_clr),
    .limit   (cfg_min_exec),
    .elapsed (timer_ok)
  );

  // ---------------- captured decoder reply ----------------
  logic             have_dec_q, have_dec_d;
  data_dir_e        dir_q, dir_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [7:0]       stat_q, stat_d;
  logic [7:0]       msg_q, msg_d;
  logic             ctx_en;

  logic xfer_finished;
  logic has_data;

  assign xfer_finished = (step_q == STEP_WAIT) && xfer_done;
  assign has_data      = ((dir_q == DIR_IN) || (dir_q == DIR_OUT)) && (len_q != '0);

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FREE:   if (sel_hit) state_d = ST_SELECT;
      ST_SELECT: if (!bus_sel) state_d = ST_CMD;
      ST_CMD:    if (xfer_finished) state_d = ST_EXEC;
      ST_EXEC: begin
        if (have_dec_q && timer_ok) begin
          if (has_data && (dir_q == DIR_IN))       state_d = ST_DIN;
          else if (has_data && (dir_q == DIR_OUT)) state_d = ST_DOUT;
          else                                     state_d = ST_STAT;
        end
      end
      ST_DIN, ST_DOUT: if (xfer_finished && timer_ok) state_d = ST_STAT;
      ST_STAT:   if (xfer_finished) state_d = ST_MSGI;
      ST_MSGI:   if (xfer_finished) state_d = ST_FREE;
      default:   state_d = ST_FREE;
    endcase
    if (bus_rst) state_d = ST_FREE;
  end

  always_comb begin
    step_d = step_q;
    if (state_d != state_q) begin
      step_d = STEP_SETTLE;
    end else begin
      unique case (step_q)
        STEP_SETTLE: step_d = STEP_LAUNCH;
        STEP_LAUNCH: step_d = STEP_WAIT;
        default:     step_d = STEP_WAIT;
      endcase
    end
  end

  assign timer_clr = bus_rst || ((state_q == ST_CMD) && (state_d == ST_EXEC));

  always_comb begin
    have_dec_d = have_dec_q;
    dir_d      = dir_q;
    len_d      = len_q;
    stat_d     = stat_q;
    msg_d      = msg_q;
    if (state_d == ST_FREE) begin
      have_dec_d = 1'b0;
      dir_d      = DIR_NONE;
      len_d      = '0;
      stat_d     = 8'h00;
      msg_d      = 8'h00;
    end else if ((state_q == ST_EXEC) && dec_valid && !have_dec_q) begin
      have_dec_d = 1'b1;
      dir_d      = data_dir_e'(dec_dir);
      len_d      = dec_len;
      stat_d     = dec_status;
      msg_d      = dec_message;
    end
  end

  assign ctx_en = (state_d == ST_FREE) || (state_q == ST_EXEC);

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_FREE;
      step_q  <= STEP_SETTLE;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      have_dec_q <= 1'b0;
      dir_q      <= DIR_NONE;
      len_q      <= '0;
      stat_q     <= 8'h00;
      msg_q      <= 8'h00;
    end else if (ctx_en) begin
      have_dec_q <= have_dec_d;
      dir_q      <= dir_d;
      len_q      <= len_d;
      stat_q     <= stat_d;
      msg_q      <= msg_d;
    end
  end

  // ---------------- outputs ----------------
  logic [2:0] lines;
  assign lines = phase_code(state_q);

  assign drv_msg    = lines[2];
  assign drv_cd     = lines[1];
  assign drv_io     = lines[0];
  assign drv_bsy    = (state_q != ST_FREE);
  assign exec_req   = (state_q == ST_EXEC) && (step_q == STEP_SETTLE);
  assign xfer_start = is_xfer_state(state_q) && (step_q == STEP_LAUNCH);
  assign tx_byte    = (state_q == ST_MSGI) ? msg_q : stat_q;

  always_comb begin
    unique case (state_q)
      ST_CMD:          xfer_len = LEN_W'(CMD_LEN);
      ST_DIN, ST_DOUT: xfer_len = len_q;
      ST_STAT, ST_MSGI: xfer_len = LEN_W'(1);
      default:         xfer_len = '0;
    endcase
  end

endmodule

// File: rtl/tgt_phase_seq_chk.sv
module tgt_phase_seq_chk #(
  parameter int ID_W    = 3,
  parameter int LEN_W   = 16,
  parameter int CMD_LEN = 6,
  localparam int DATA_W = 1 << ID_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rst,
  input logic              bus_sel,
  input logic              bus_bsy_in,
  input logic [DATA_W-1:0] bus_data_in,
  input logic [ID_W-1:0]   cfg_id,
  input logic              cfg_lun_present,
  input logic              xfer_start,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              xfer_done,
  input logic              drv_bsy,
  input logic              drv_msg,
  input logic              drv_cd,
  input logic              drv_io
);

  logic [2:0] lines;
  assign lines = {drv_msg, drv_cd, drv_io};

  logic inflight_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     inflight_q <= 1'b0;
    else if (bus_rst || xfer_done)  inflight_q <= 1'b0;
    else if (xfer_start)            inflight_q <= 1'b1;
  end

  AST_FREE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_bsy |-> (lines == 3'b000) && !xfer_start) else $error("R1 lines not released"); // R1

  AST_SEL_RAISES_BSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_bsy && bus_sel && !bus_bsy_in && bus_data_in[cfg_id] && cfg_lun_present && !bus_rst)
    |=> drv_bsy) else $error("R2 selection not answered"); // R2

  AST_NO_LUN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_bsy && !cfg_lun_present) |=> !drv_bsy) else $error("R3 selected without unit"); // R3

  AST_CMD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && lines == 3'b010) |-> xfer_len == LEN_W'(CMD_LEN)) else $error("R4 cmd length"); // R4

  AST_TAIL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && (lines == 3'b011 || lines == 3'b111)) |-> xfer_len == LEN_W'(1)) else $error("R9 tail length"); // R9

  AST_BUS_RST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !drv_bsy) else $error("R11 bus reset ignored"); // R11

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start) else $error("R12 start longer than one cycle"); // R12

  AST_START_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $stable(lines)) else $error("R12 lines moved at start"); // R12

  AST_LINES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_q && !xfer_done && !bus_rst) |=> $stable(lines)) else $error("R12 lines moved in transfer"); // R12

endmodule

bind tgt_phase_seq tgt_phase_seq_chk #(
  .ID_W    (ID_W),
  .LEN_W   (LEN_W),
  .CMD_LEN (CMD_LEN)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_rst         (bus_rst),
  .bus_sel         (bus_sel),
  .bus_bsy_in      (bus_bsy_in),
  .bus_data_in     (bus_data_in),
  .cfg_id          (cfg_id),
  .cfg_lun_present (cfg_lun_present),
  .xfer_start      (xfer_start),
  .xfer_len        (xfer_len),
  .xfer_done       (xfer_done),
  .drv_bsy         (drv_bsy),
  .drv_msg         (drv_msg),
  .drv_cd          (drv_cd),
  .drv_io          (drv_io)
);

// File: tb/tgt_phase_seq_bench.sv
`timescale 1ns/1ps
module tgt_phase_seq_bench;

  localparam int ID_W  = 3;
  localparam int CNT_W = 16;
  localparam int LEN_W = 16;
  localparam int DW    = 1 << ID_W;
  localparam logic [ID_W-1:0] TGT_ID = 3'd5;

  typedef struct packed {
    logic [15:0] min_exec;
    logic [1:0]  dir;
    logic [15:0] len;
    logic [7:0]  st;
    logic [7:0]  mg;
  } vec_t;

  // min_exec, dir (0 none, 1 in, 2 out), len, status, message
  localparam vec_t VECS [5] = '{
    '{16'd0,  2'd1, 16'd4, 8'h00, 8'h00},
    '{16'd5,  2'd2, 16'd2, 8'h02, 8'h00},
    '{16'd3,  2'd1, 16'd0, 8'h22, 8'h80},
    '{16'd0,  2'd0, 16'd7, 8'h00, 8'h0A},
    '{16'd12, 2'd2, 16'd1, 8'h08, 8'h05}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic bus_rst, bus_sel, bus_bsy_in;
  logic [DW-1:0] bus_data_in;
  logic [ID_W-1:0] cfg_id;
  logic cfg_lun_present;
  logic [CNT_W-1:0] cfg_min_exec;
  logic exec_req, dec_valid;
  logic [1:0] dec_dir;
  logic [LEN_W-1:0] dec_len;
  logic [7:0] dec_status, dec_message;
  logic xfer_start, xfer_done;
  logic [LEN_W-1:0] xfer_len;
  logic [7:0] tx_byte;
  logic drv_bsy, drv_msg, drv_cd, drv_io;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tgt_phase_seq #(.ID_W(ID_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .CMD_LEN(6)) u_tgt_phase_seq (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bus_sel(bus_sel),
    .bus_bsy_in(bus_bsy_in), .bus_data_in(bus_data_in), .cfg_id(cfg_id),
    .cfg_lun_present(cfg_lun_present), .cfg_min_exec(cfg_min_exec),
    .exec_req(exec_req), .dec_valid(dec_valid), .dec_dir(dec_dir),
    .dec_len(dec_len), .dec_status(dec_status), .dec_message(dec_message),
    .xfer_start(xfer_start), .xfer_len(xfer_len), .xfer_done(xfer_done),
    .tx_byte(tx_byte), .drv_bsy(drv_bsy), .drv_msg(drv_msg),
    .drv_cd(drv_cd), .drv_io(drv_io)
  );

  function automatic logic [2:0] lines();
    return {drv_msg, drv_cd, drv_io};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_start();
    logic [2:0] prev;
    int guard = 0;
    prev = lines();
    @(negedge clk);
    while (!xfer_start && guard < 1000) begin
      prev = lines();
      @(negedge clk);
      guard++;
    end
    chk(xfer_start == 1'b1, "R12 start seen", xfer_start, 1);
    chk(prev == lines(), "R12 lines settled before start", prev, lines());
  endtask

  task automatic do_done();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic select_me();
    @(negedge clk);
    bus_data_in = DW'(1) << TGT_ID; bus_sel = 1'b1; bus_bsy_in = 1'b0;
    @(negedge clk);
    chk(drv_bsy == 1'b1, "R2 busy after selection", drv_bsy, 1);
    bus_sel = 1'b0; bus_data_in = '0;
    @(negedge clk);
    chk(lines() == 3'b010, "R4 command phase after SEL release", lines(), 3'b010);
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    int exp_n;
    bit has_data;
    cfg_min_exec = v.min_exec;
    select_me();
    wait_start();
    chk(xfer_len == 16'd6, "R4 command length", xfer_len, 6);
    chk(lines() == 3'b010, "R5 command code", lines(), 3'b010);
    do_done();
    chk(exec_req == 1'b1, "R6 exec_req on first wait cycle", exec_req, 1);
    dec_valid = 1'b1; dec_dir = v.dir; dec_len = v.len;
    dec_status = v.st; dec_message = v.mg;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      dec_valid = 1'b0;
      if (n == 1) chk(exec_req == 1'b0, "R6 exec_req single cycle", exec_req, 0);
    end while (lines() == 3'b010 && n < 1000);
    exp_n = ((v.min_exec < 1) ? 1 : int'(v.min_exec)) + 1;
    chk(n == exp_n, "R7 execution hold cycles", n, exp_n);
    has_data = (v.dir == 2'd1 || v.dir == 2'd2) && v.len != 0;
    if (has_data) begin
      chk(lines() == ((v.dir == 2'd1) ? 3'b001 : 3'b000), "R5 data phase code",
          lines(), (v.dir == 2'd1) ? 3'b001 : 3'b000);
      wait_start();
      chk(xfer_len == v.len, "R6 data length", xfer_len, v.len);
      do_done();
    end else begin
      chk(lines() == 3'b011, "R8 direct to status", lines(), 3'b011);
    end
    wait_start();
    chk(lines() == 3'b011, "R5 status code", lines(), 3'b011);
    chk(tx_byte == v.st, "R9 status byte", tx_byte, v.st);
    chk(xfer_len == 16'd1, "R9 status length", xfer_len, 1);
    do_done();
    wait_start();
    chk(lines() == 3'b111, "R5 message-in code", lines(), 3'b111);
    chk(tx_byte == v.mg, "R9 message byte", tx_byte, v.mg);
    do_done();
    chk(drv_bsy == 1'b0 && lines() == 3'b000, "R1 bus free after message",
        {drv_bsy, lines()}, 0);
    chk(tx_byte == 8'h00, "R10 bytes cleared in bus free", tx_byte, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_rst = 1'b0; bus_sel = 1'b0; bus_bsy_in = 1'b0;
    bus_data_in = '0; cfg_id = TGT_ID; cfg_lun_present = 1'b1; cfg_min_exec = '0;
    dec_valid = 1'b0; dec_dir = '0; dec_len = '0; dec_status = '0; dec_message = '0;
    xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk({drv_bsy, lines(), xfer_start} == 5'b0, "R1 reset lines", {drv_bsy, lines(), xfer_start}, 0);
    chk(xfer_len == '0 && tx_byte == 8'h00, "R1 reset length and byte", xfer_len, 0);

    // table of commands
    foreach (VECS[i]) run_vec(VECS[i]);

    // wrong ID bit
    @(negedge clk);
    bus_data_in = DW'(1) << 3; bus_sel = 1'b1; bus_bsy_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(drv_bsy == 1'b0, "R2 wrong ID ignored", drv_bsy, 0);
    // bus already busy
    bus_data_in = DW'(1) << TGT_ID; bus_bsy_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(drv_bsy == 1'b0, "R2 busy bus ignored", drv_bsy, 0);
    // no unit attached
    bus_bsy_in = 1'b0; cfg_lun_present = 1'b0;
    repeat (3) @(negedge clk);
    chk(drv_bsy == 1'b0, "R3 no unit ignored", drv_bsy, 0);
    bus_sel = 1'b0; bus_data_in = '0; cfg_lun_present = 1'b1;
    @(negedge clk);

    // bus reset during command transfer
    cfg_min_exec = 16'd4;
    select_me();
    wait_start();
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    chk(drv_bsy == 1'b0 && lines() == 3'b000, "R11 reset in command phase",
        {drv_bsy, lines()}, 0);
    chk(xfer_len == '0, "R11 length cleared", xfer_len, 0);

    // bus reset during execution wait after decoder reply
    select_me();
    wait_start();
    do_done();
    dec_valid = 1'b1; dec_dir = 2'd1; dec_len = 16'd9; dec_status = 8'h44; dec_message = 8'h11;
    @(negedge clk);
    dec_valid = 1'b0;
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    chk(drv_bsy == 1'b0 && lines() == 3'b000, "R11 reset in execution wait",
        {drv_bsy, lines()}, 0);
    chk(tx_byte == 8'h00, "R11 captured status dropped", tx_byte, 0);

    // a full command still runs after the resets
    run_vec(VECS[1]);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule